// File: doc/BRIEF.md
# Spare-Row Repair Memory

This block is a small synchronous RAM that always presents a fixed number of logical rows. The physical storage holds a few more rows than that. A short repair table, written through a configuration port, marks logical rows as bad. Each table entry owns one spare row. Every read and every write passes through the row decoder, which compares the row address with the table. A matching access is sent to the spare row without any notice to the user, so the memory appears free of defects.

Repairs are loaded once, in the manner of blowing fuses, and are then frozen by a lock command. If more repair requests arrive than there are spares, the block raises a sticky flag. The flag marks the part as rejected; the capacity is not reduced. A read returns its data exactly one cycle after the request, whether or not the row has been redirected.

Top module: `rowspare_mem`

## Requirements
- R1: A read request (req_valid=1, req_we=0) raises rd_valid in the next cycle, and rd_data then carries the last value written to that logical row. A write (req_we=1) stores req_wdata at the clock edge. Remapped and plain rows have the same latency.
- R2: A repair request (cfg_valid=1 with cfg_row, table not locked) claims the lowest-numbered free entry k. From then on, accesses to that logical row go to raw row LOG_ROWS+k.
- R3: A logical row that no valid entry names uses raw row equal to its own index. A stuck raw row that has been repaired is never visible at rd_data.
- R4: When two valid entries name the same logical row, the entry with the lower index decides which spare is used.
- R5: A repair request made while every entry is in use sets unrepairable and leaves the table unchanged. The flag stays set until reset.
- R6: cfg_lock sets locked. After that, cfg_valid has no effect on the table or on unrepairable.
- R7: After reset, rd_valid, rd_data, locked and unrepairable are all zero, and no row is remapped.
- R8: A cycle without a read request drives rd_valid low in the next cycle and holds rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Repair request strobe |
| cfg_row | input | $clog2(LOG_ROWS) | Logical row to repair |
| cfg_lock | input | 1 | Freeze the repair table |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(LOG_ROWS) | Logical row address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| locked | output | 1 | Repair table frozen |
| unrepairable | output | 1 | Sticky: more faults than spares |

## Verification
The assertions check these properties on every cycle: read latency, the quiet behaviour of rd_valid and rd_data between reads, the stickiness and cause of the unrepairable flag, entry allocation, and the fact that the table does not change once locked. Only the bench scenarios can show that redirection works. In those scenarios, raw rows are forced to stuck values, and the bench observes which logical rows still return their written data. This covers the lower-entry priority, the spare numbering, requests ignored after lock, and a rejected request that leaves the table intact.

// File: rtl/rowspare_pkg.sv
package rowspare_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic valid, input logic we);
        if (!valid) return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/rowspare_table.sv
module rowspare_table #(
    parameter int LOG_ROWS = 16,
    parameter int SPARES   = 2,
    parameter int ROW_W    = 4,
    parameter int RAW_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic             cfg_lock,
    input  logic [ROW_W-1:0] lk_row,
    output logic [RAW_W-1:0] lk_raw,
    output logic             locked,
    output logic             unrepairable
);
    localparam int IDX_W = (SPARES > 1) ? $clog2(SPARES) : 1;

    typedef struct packed {
        logic [SPARES-1:0]            vld;
        logic [SPARES-1:0][ROW_W-1:0] tag;
        logic                         locked;
        logic                         unrep;
    } tbl_t;

    tbl_t             st_d, st_q;
    logic             full;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] hit_idx;
    logic             hit;

    assign full = &st_q.vld;

    // lowest free entry: scan downwards so the smallest index is kept
    always_comb begin
        free_idx = '0;
        for (int i = SPARES - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) free_idx = IDX_W'(i);
        end
    end

    // lookup: lowest matching valid entry wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = SPARES - 1; i >= 0; i--) begin
            if (st_q.vld[i] && st_q.tag[i] == lk_row) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign lk_raw = hit ? (RAW_W'(LOG_ROWS) + RAW_W'(hit_idx)) : RAW_W'(lk_row);

    always_comb begin
        st_d = st_q;
        if (!st_q.locked) begin
            if (cfg_valid) begin
                if (full) begin
                    st_d.unrep = 1'b1;
                end else begin
                    st_d.vld[free_idx] = 1'b1;
                    st_d.tag[free_idx] = cfg_row;
                end
            end
            if (cfg_lock) st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked       = st_q.locked;
    assign unrepairable = st_q.unrep;

    a_r5_unrep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unrep |=> st_q.unrep);

    a_r5_unrep_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.unrep) |-> $past(cfg_valid && !st_q.locked && full));

    a_r5_full_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && full) |=> ($stable(st_q.vld) && $stable(st_q.tag)));

    a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> ($stable(st_q.vld) && $stable(st_q.tag) && st_q.locked));

    a_r2_claims_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !st_q.locked && !full) |=>
            ($countones(st_q.vld) == $past($countones(st_q.vld)) + 1));

endmodule

// File: rtl/rowspare_array.sv
module rowspare_array #(
    parameter int DATA_W   = 16,
    parameter int RAW_ROWS = 18,
    parameter int RAW_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [RAW_W-1:0]  raw_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] rows [RAW_ROWS];
    logic [DATA_W-1:0] sel;
    rd_t               rd_d, rd_q;

    for (genvar i = 0; i < RAW_ROWS; i++) begin : g_row
        logic [DATA_W-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (wr_en && raw_addr == RAW_W'(i)) row_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) row_q <= '0;
            else        row_q <= row_d;
        end

        assign rows[i] = row_q;
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < RAW_ROWS; i++) begin
            if (raw_addr == RAW_W'(i)) sel = rows[i];
        end
    end

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = rd_en ? sel : rd_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    a_r1_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> (int'(raw_addr) < RAW_ROWS));

endmodule

// File: rtl/rowspare_mem.sv
module rowspare_mem
    import rowspare_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int LOG_ROWS = 16,
    parameter int SPARES   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_valid,
    input  logic [$clog2(LOG_ROWS)-1:0] cfg_row,
    input  logic                        cfg_lock,
    input  logic                        req_valid,
    input  logic                        req_we,
    input  logic [$clog2(LOG_ROWS)-1:0] req_row,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        locked,
    output logic                        unrepairable
);
    localparam int ROW_W    = $clog2(LOG_ROWS);
    localparam int RAW_ROWS = LOG_ROWS + SPARES;
    localparam int RAW_W    = $clog2(RAW_ROWS);

    op_e              op;
    logic [RAW_W-1:0] raw_row;

    assign op = decode_op(req_valid, req_we);

    rowspare_table #(
        .LOG_ROWS (LOG_ROWS),
        .SPARES   (SPARES),
        .ROW_W    (ROW_W),
        .RAW_W    (RAW_W)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .cfg_row      (cfg_row),
        .cfg_lock     (cfg_lock),
        .lk_row       (req_row),
        .lk_raw       (raw_row),
        .locked       (locked),
        .unrepairable (unrepairable)
    );

    rowspare_array #(
        .DATA_W   (DATA_W),
        .RAW_ROWS (RAW_ROWS),
        .RAW_W    (RAW_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (op == OP_WRITE),
        .rd_en    (op == OP_READ),
        .raw_addr (raw_row),
        .wdata    (req_wdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> rd_valid);

    a_r8_quiet_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> !rd_valid);

    a_r8_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> $stable(rd_data));

endmodule

// File: tb/rowspare_mem_bench.sv
module rowspare_mem_bench;
    localparam int DW = 16;
    localparam int LR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [3:0]    cfg_row = '0;
    logic          cfg_lock = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [3:0]    req_row = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          locked;
    logic          unrepairable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model     [LR];
    bit            stuck_en  [LR];
    logic [DW-1:0] stuck_val [LR];

    always #2 clk = ~clk;

    rowspare_mem u_rowspare_mem (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_row(cfg_row),
        .cfg_lock(cfg_lock), .req_valid(req_valid), .req_we(req_we),
        .req_row(req_row), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .locked(locked), .unrepairable(unrepairable)
    );

    function automatic logic [DW-1:0] exp_read(input int row);
        return stuck_en[row] ? stuck_val[row] : model[row];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < LR; i++) begin
            model[i]    = '0;
            stuck_en[i] = 1'b0;
            stuck_val[i] = '0;
        end
    endtask

    task automatic wr(input int row, input logic [DW-1:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_row = 4'(row); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        model[row] = d;
        check("R8 rd_valid after write", 32'(rd_valid), 32'd0);
    endtask

    task automatic rd(input int row, input string tag);
        req_valid = 1'b1; req_we = 1'b0; req_row = 4'(row);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({tag, " rd_data"}, 32'(rd_data), 32'(exp_read(row)));
    endtask

    task automatic repair(input int row);
        cfg_valid = 1'b1; cfg_row = 4'(row);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic lock();
        cfg_lock = 1'b1;
        @(negedge clk);
        cfg_lock = 1'b0;
    endtask

    task automatic random_ops(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            int row;
            row = int'($urandom_range(0, LR - 1));
            if ($urandom_range(0, 1) == 1) wr(row, DW'($urandom));
            else                           rd(row, tag);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        int seed;
        logic [DW-1:0] held;
        seed = int'($urandom(32'h5EED));
        do_reset();

        // R7: reset state
        check("R7 rd_valid", 32'(rd_valid), 32'd0);
        check("R7 rd_data", 32'(rd_data), 32'd0);
        check("R7 locked", 32'(locked), 32'd0);
        check("R7 unrepairable", 32'(unrepairable), 32'd0);
        for (int i = 0; i < LR; i++) rd(i, "R7 empty row");

        // R1 / R8: plain traffic, no repairs
        for (int i = 0; i < LR; i++) wr(i, DW'(16'hA000 + i));
        random_ops(300, "R1 plain");
        rd(5, "R1 before idle");
        held = rd_data;
        @(negedge clk);
        check("R8 idle rd_valid", 32'(rd_valid), 32'd0);
        check("R8 idle rd_data held", 32'(rd_data), 32'(held));

        // R4 / R6: duplicate repair of row 3, lock, ignored request for row 7
        repair(3);
        repair(3);
        check("R4 no flag with spares", 32'(unrepairable), 32'd0);
        lock();
        check("R6 locked", 32'(locked), 32'd1);
        repair(7);
        check("R6 no flag after lock", 32'(unrepairable), 32'd0);

        force u_rowspare_mem.u_array.g_row[3].row_q  = 16'hDEAD;
        force u_rowspare_mem.u_array.g_row[17].row_q = 16'hBEEF;
        force u_rowspare_mem.u_array.g_row[7].row_q  = 16'h0F0F;
        stuck_en[7] = 1'b1; stuck_val[7] = 16'h0F0F;

        for (int i = 0; i < LR; i++) wr(i, DW'($urandom));
        rd(3, "R4 lower entry wins");
        rd(7, "R6 request after lock ignored");
        rd(0, "R3 unrepaired row");
        random_ops(300, "R3 mixed");
        wr(3, 16'h1357);
        rd(3, "R4 row3 after write");

        // R2: entry 0 owns raw row LOG_ROWS+0
        force u_rowspare_mem.u_array.g_row[16].row_q = 16'h1234;
        stuck_en[3] = 1'b1; stuck_val[3] = 16'h1234;
        rd(3, "R2 spare numbering");
        release u_rowspare_mem.u_array.g_row[3].row_q;
        release u_rowspare_mem.u_array.g_row[7].row_q;
        release u_rowspare_mem.u_array.g_row[16].row_q;
        release u_rowspare_mem.u_array.g_row[17].row_q;

        // R5: too many repairs
        do_reset();
        check("R7 flag cleared by reset", 32'(unrepairable), 32'd0);
        repair(1);
        repair(2);
        check("R5 flag low at capacity", 32'(unrepairable), 32'd0);
        repair(9);
        check("R5 flag set", 32'(unrepairable), 32'd1);
        repeat (3) @(negedge clk);
        check("R5 flag sticky", 32'(unrepairable), 32'd1);
        lock();
        check("R5 flag sticky after lock", 32'(unrepairable), 32'd1);

        force u_rowspare_mem.u_array.g_row[1].row_q = 16'h1111;
        force u_rowspare_mem.u_array.g_row[2].row_q = 16'h2222;
        force u_rowspare_mem.u_array.g_row[9].row_q = 16'h5555;
        stuck_en[9] = 1'b1; stuck_val[9] = 16'h5555;
        for (int i = 0; i < LR; i++) wr(i, DW'($urandom));
        rd(9, "R5 rejected row not remapped");
        rd(1, "R3 repaired row 1");
        rd(2, "R3 repaired row 2");
        random_ops(200, "R3 second part");
        release u_rowspare_mem.u_array.g_row[1].row_q;
        release u_rowspare_mem.u_array.g_row[2].row_q;
        release u_rowspare_mem.u_array.g_row[9].row_q;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule